// File: doc/BRIEF.md
# Per-CPU Private Interrupt Tracker

This block holds the state of one CPU's thirty-two private interrupts (IDs 0..31, where 0..15 are software-generated and 16..31 are peripheral lines) and keeps that CPU's best-pending record up to date one step at a time. A set of input pins carries the peripheral lines. A small write port programs the per-ID enable, pending, active, group, group-modifier, trigger-mode and priority state. The distributor-wide group enables and the security-disable control arrive as plain inputs.

When `eval` is pulsed, the tracker takes the best record offered by the shared-interrupt scanner. It looks for an eligible private interrupt that beats that record. If it finds one, that interrupt becomes the new record. If it does not, the offered record is kept. In that case the tracker raises a one-cycle full-rescan request when the offered record is a live private interrupt, because that interrupt may have lost eligibility and only a full scan can find its successor. Driving a software-generated ID through the pins is illegal and is flagged.

Top module: `pirq_tracker`

## Requirements
- R1: After reset, `best_id` is 1023, `best_prio` is 0xFF, `best_grp` is 0, and `rescan_req`, `irq_pend` and `sgi_pin_err` are low.
- R2: An ID is eligible only when its pending latch is set (or it is level-mode with its pin high), it is enabled, it is not active, and its group class is enabled.
- R3: Group class is 2 (non-secure group 1) when the group bit is 1. It is 1 (secure group 1) when the group bit is 0 and the modifier is 1. Otherwise it is 0. While `ctl_ds` is high the modifier is treated as 0. Each class is enabled by `ctl_grp0_en`, `ctl_grp1s_en` or `ctl_grp1ns_en`.
- R4: Among eligible IDs the lowest priority value wins, with ties going to the lowest ID. The winner replaces the offered record when its priority is lower, or when its priority is equal and its ID is lower than or equal to the offered ID.
- R5: When a private winner replaces the record, `best_grp` carries the winner's group class.
- R6: When no private winner replaces the record, the offered ID, priority and group are kept. `rescan_req` is high for exactly one cycle if the offered priority is not 0xFF and the offered ID is below 32.
- R7: An edge-mode ID (trigger bit 1) sets its pending latch on a rising edge of its pin. The latch stays set after the pin falls, until a pending write of 0 clears it.
- R8: A level-mode ID (trigger bit 0) with a clear latch is eligible only while its pin is high.
- R9: Pins 0..15 never affect eligibility. If any of them is high in a cycle, `sgi_pin_err` is high in the next cycle.
- R10: `irq_pend` is high exactly when `best_prio` differs from 0xFF.
- R11: Outputs change only in the cycle after an `eval` pulse and hold otherwise. Writes use `wr_kind` codes 0 enable, 1 pending, 2 active, 3 group, 4 modifier, 5 trigger mode (single-bit fields from `wr_data[0]`) and 6 priority (`wr_data` in full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Private interrupt lines, bit n for ID n |
| ctl_grp0_en | input | 1 | Group 0 enable |
| ctl_grp1s_en | input | 1 | Secure group 1 enable |
| ctl_grp1ns_en | input | 1 | Non-secure group 1 enable |
| ctl_ds | input | 1 | Security disabled: modifier forced to 0 |
| wr_en | input | 1 | State write strobe |
| wr_kind | input | 3 | Field selector |
| wr_id | input | 5 | Target private ID |
| wr_data | input | 8 | Write value |
| eval | input | 1 | Update strobe for the offered record |
| in_id | input | 10 | Offered best ID |
| in_prio | input | 8 | Offered best priority |
| in_grp | input | 2 | Offered best group class |
| best_id | output | 10 | Resulting best ID |
| best_prio | output | 8 | Resulting best priority |
| best_grp | output | 2 | Resulting best group class |
| rescan_req | output | 1 | One-cycle full-rescan request |
| irq_pend | output | 1 | Best record is live |
| sgi_pin_err | output | 1 | A software-generated ID was driven on a pin |

## Verification
A corrupted pending, enable, active or group bit shows up as a wrong `best_id` or `best_grp` on the first `eval` after the damage. The bench reaches each of these bits through a sequence that flips exactly one term at a time. A faulty comparator shows as a wrong choice between two equal or adjacent priorities offered against a private or shared record, and a faulty rescan rule shows as a missing or extra `rescan_req` one cycle after the strobe. A broken edge latch is seen one evaluation after the pin falls, when the interrupt disappears too early or cannot be cleared.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int PIRQ_NUM  = 32;
    localparam int PIRQ_SGI  = 16;
    localparam int PIRQ_PW   = 8;
    localparam int PIRQ_IW   = 10;
    localparam int PIRQ_LW   = $clog2(PIRQ_NUM);

    typedef enum logic [2:0] {
        WK_ENABLE  = 3'd0,
        WK_PENDING = 3'd1,
        WK_ACTIVE  = 3'd2,
        WK_GROUP   = 3'd3,
        WK_GRPMOD  = 3'd4,
        WK_EDGE    = 3'd5,
        WK_PRIO    = 3'd6
    } wr_kind_e;

    typedef enum logic [1:0] {
        GC_G0   = 2'd0,
        GC_G1S  = 2'd1,
        GC_G1NS = 2'd2
    } grp_cls_e;

    typedef struct packed {
        logic [PIRQ_IW-1:0] id;
        logic [PIRQ_PW-1:0] prio;
        grp_cls_e           grp;
    } best_rec_t;

    function automatic grp_cls_e grp_of(input logic group_bit, input logic mod_eff);
        if (group_bit)
            return GC_G1NS;
        else if (mod_eff)
            return GC_G1S;
        return GC_G0;
    endfunction

    function automatic logic beats(input logic [PIRQ_PW-1:0] c_prio,
                                   input logic [PIRQ_IW-1:0] c_id,
                                   input logic [PIRQ_PW-1:0] r_prio,
                                   input logic [PIRQ_IW-1:0] r_id);
        return (c_prio < r_prio) || ((c_prio == r_prio) && (c_id <= r_id));
    endfunction

endpackage

// File: rtl/pirq_state.sv
module pirq_state
    import pirq_pkg::*;
#(
    parameter int NUM = PIRQ_NUM,
    parameter int SGI = PIRQ_SGI,
    parameter int PW  = PIRQ_PW,
    localparam int LW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NUM-1:0] pin_in,
    input  logic          wr_en,
    input  wr_kind_e      wr_kind,
    input  logic [LW-1:0] wr_id,
    input  logic [PW-1:0] wr_data,
    output logic [NUM-1:0] pend_q,
    output logic [NUM-1:0] en_q,
    output logic [NUM-1:0] act_q,
    output logic [NUM-1:0] grp_q,
    output logic [NUM-1:0] mod_q,
    output logic [NUM-1:0] edge_q,
    output logic [NUM-1:0] lvl_q,
    output logic [PW-1:0]  prio_q [NUM],
    output logic           sgi_err_q
);
    localparam logic [NUM-1:0] PPI_MASK = {{(NUM-SGI){1'b1}}, {SGI{1'b0}}};

    logic [NUM-1:0] pin_prev;
    logic [NUM-1:0] rise;

    assign rise = pin_in & ~pin_prev & PPI_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev  <= '0;
            lvl_q     <= '0;
            sgi_err_q <= 1'b0;
        end else begin
            pin_prev  <= pin_in;
            lvl_q     <= pin_in & PPI_MASK;
            sgi_err_q <= |pin_in[SGI-1:0];
        end
    end

    for (genvar g = 0; g < NUM; g++) begin : g_id
        logic hit;
        assign hit = wr_en && (wr_id == LW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                en_q[g]   <= 1'b0;
                act_q[g]  <= 1'b0;
                grp_q[g]  <= 1'b0;
                mod_q[g]  <= 1'b0;
                edge_q[g] <= 1'b0;
                prio_q[g] <= '0;
            end else begin
                if (hit && wr_kind == WK_PENDING)
                    pend_q[g] <= wr_data[0];
                else if (rise[g] && edge_q[g])
                    pend_q[g] <= 1'b1;
                if (hit && wr_kind == WK_ENABLE) en_q[g]   <= wr_data[0];
                if (hit && wr_kind == WK_ACTIVE) act_q[g]  <= wr_data[0];
                if (hit && wr_kind == WK_GROUP)  grp_q[g]  <= wr_data[0];
                if (hit && wr_kind == WK_GRPMOD) mod_q[g]  <= wr_data[0];
                if (hit && wr_kind == WK_EDGE)   edge_q[g] <= wr_data[0];
                if (hit && wr_kind == WK_PRIO)   prio_q[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pirq_elig.sv
module pirq_elig
    import pirq_pkg::*;
#(
    parameter int NUM = PIRQ_NUM
) (
    input  logic [NUM-1:0] pend_q,
    input  logic [NUM-1:0] en_q,
    input  logic [NUM-1:0] act_q,
    input  logic [NUM-1:0] grp_q,
    input  logic [NUM-1:0] mod_q,
    input  logic [NUM-1:0] edge_q,
    input  logic [NUM-1:0] lvl_q,
    input  logic           ctl_grp0_en,
    input  logic           ctl_grp1s_en,
    input  logic           ctl_grp1ns_en,
    input  logic           ctl_ds,
    output logic [NUM-1:0] mod_eff,
    output logic [NUM-1:0] elig
);
    logic [NUM-1:0] raw;
    logic [NUM-1:0] gmask;

    always_comb begin
        mod_eff = ctl_ds ? '0 : mod_q;
        gmask   = '0;
        if (ctl_grp1ns_en) gmask = gmask | grp_q;
        if (ctl_grp1s_en)  gmask = gmask | (~grp_q & mod_eff);
        if (ctl_grp0_en)   gmask = gmask | (~grp_q & ~mod_eff);
        raw  = pend_q | (~edge_q & lvl_q);
        elig = raw & en_q & ~act_q & gmask;
    end
endmodule

// File: rtl/pirq_pick.sv
module pirq_pick
    import pirq_pkg::*;
#(
    parameter int NUM = PIRQ_NUM,
    parameter int PW  = PIRQ_PW,
    localparam int LW = $clog2(NUM)
) (
    input  logic [NUM-1:0] elig,
    input  logic [PW-1:0]  prio_q [NUM],
    output logic           found,
    output logic [LW-1:0]  win_id,
    output logic [PW-1:0]  win_prio
);
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM; i++) begin
            if (elig[i] && (!found || prio_q[i] < win_prio)) begin
                found    = 1'b1;
                win_id   = LW'(i);
                win_prio = prio_q[i];
            end
        end
    end
endmodule

// File: rtl/pirq_tracker.sv
module pirq_tracker
    import pirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PIRQ_NUM-1:0] pin_in,
    input  logic                ctl_grp0_en,
    input  logic                ctl_grp1s_en,
    input  logic                ctl_grp1ns_en,
    input  logic                ctl_ds,
    input  logic                wr_en,
    input  logic [2:0]          wr_kind,
    input  logic [PIRQ_LW-1:0]  wr_id,
    input  logic [PIRQ_PW-1:0]  wr_data,
    input  logic                eval,
    input  logic [PIRQ_IW-1:0]  in_id,
    input  logic [PIRQ_PW-1:0]  in_prio,
    input  logic [1:0]          in_grp,
    output logic [PIRQ_IW-1:0]  best_id,
    output logic [PIRQ_PW-1:0]  best_prio,
    output logic [1:0]          best_grp,
    output logic                rescan_req,
    output logic                irq_pend,
    output logic                sgi_pin_err
);
    localparam int NUM = PIRQ_NUM;
    localparam int LW  = PIRQ_LW;
    localparam int PW  = PIRQ_PW;
    localparam int IW  = PIRQ_IW;

    logic [NUM-1:0] pend_q, en_q, act_q, grp_q, mod_q, edge_q, lvl_q;
    logic [NUM-1:0] mod_eff, elig;
    logic [PW-1:0]  prio_q [NUM];
    logic           found;
    logic [LW-1:0]  win_id;
    logic [PW-1:0]  win_prio;
    logic           take;
    best_rec_t      rec_q, offer, cand;
    logic           rescan_q, irq_q;

    pirq_state #(.NUM(NUM), .SGI(PIRQ_SGI), .PW(PW)) u_state (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind_e'(wr_kind)),
        .wr_id    (wr_id),
        .wr_data  (wr_data),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .act_q    (act_q),
        .grp_q    (grp_q),
        .mod_q    (mod_q),
        .edge_q   (edge_q),
        .lvl_q    (lvl_q),
        .prio_q   (prio_q),
        .sgi_err_q(sgi_pin_err)
    );

    pirq_elig #(.NUM(NUM)) u_elig (
        .pend_q       (pend_q),
        .en_q         (en_q),
        .act_q        (act_q),
        .grp_q        (grp_q),
        .mod_q        (mod_q),
        .edge_q       (edge_q),
        .lvl_q        (lvl_q),
        .ctl_grp0_en  (ctl_grp0_en),
        .ctl_grp1s_en (ctl_grp1s_en),
        .ctl_grp1ns_en(ctl_grp1ns_en),
        .ctl_ds       (ctl_ds),
        .mod_eff      (mod_eff),
        .elig         (elig)
    );

    pirq_pick #(.NUM(NUM), .PW(PW)) u_pick (
        .elig    (elig),
        .prio_q  (prio_q),
        .found   (found),
        .win_id  (win_id),
        .win_prio(win_prio)
    );

    always_comb begin
        offer.id   = in_id;
        offer.prio = in_prio;
        offer.grp  = grp_cls_e'(in_grp);
        cand.id    = IW'(win_id);
        cand.prio  = win_prio;
        cand.grp   = grp_of(grp_q[win_id], mod_eff[win_id]);
        take       = found && beats(cand.prio, cand.id, offer.prio, offer.id);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q.id   <= '1;
            rec_q.prio <= '1;
            rec_q.grp  <= GC_G0;
            rescan_q   <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            rescan_q <= 1'b0;
            if (eval) begin
                if (take) begin
                    rec_q <= cand;
                    irq_q <= (cand.prio != '1);
                end else begin
                    rec_q    <= offer;
                    irq_q    <= (offer.prio != '1);
                    rescan_q <= (offer.prio != '1) && (offer.id < IW'(NUM));
                end
            end
        end
    end

    assign best_id    = rec_q.id;
    assign best_prio  = rec_q.prio;
    assign best_grp   = rec_q.grp;
    assign rescan_req = rescan_q;
    assign irq_pend   = irq_q;
endmodule

// File: rtl/pirq_tracker_chk.sv
module pirq_tracker_chk
    import pirq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [PIRQ_NUM-1:0] pin_in,
    input logic                eval,
    input logic [PIRQ_IW-1:0]  in_id,
    input logic [PIRQ_PW-1:0]  in_prio,
    input logic [PIRQ_IW-1:0]  best_id,
    input logic [PIRQ_PW-1:0]  best_prio,
    input logic [1:0]          best_grp,
    input logic                rescan_req,
    input logic                irq_pend,
    input logic                sgi_pin_err
);
    assert_irq_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq_pend == (best_prio != '1));

    assert_rescan_cause_R6: assert property (@(posedge clk) disable iff (rst)
        rescan_req |-> ($past(eval) && $past(in_prio) != '1 && $past(in_id) < PIRQ_IW'(PIRQ_NUM)));

    assert_rescan_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        rescan_req |-> (best_id == $past(in_id) && best_prio == $past(in_prio)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !eval |=> ($stable(best_id) && $stable(best_prio) && $stable(best_grp)));

    assert_not_worse_R4: assert property (@(posedge clk) disable iff (rst)
        eval |=> (best_prio <= $past(in_prio)));

    assert_sgi_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (|pin_in[PIRQ_SGI-1:0]) |=> sgi_pin_err);
endmodule

bind pirq_tracker pirq_tracker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .eval       (eval),
    .in_id      (in_id),
    .in_prio    (in_prio),
    .best_id    (best_id),
    .best_prio  (best_prio),
    .best_grp   (best_grp),
    .rescan_req (rescan_req),
    .irq_pend   (irq_pend),
    .sgi_pin_err(sgi_pin_err)
);

// File: tb/pirq_tracker_bench.sv
module pirq_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] NONE_ID = 10'd1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_in = '0;
    logic        ctl_grp0_en = 1'b1, ctl_grp1s_en = 1'b1, ctl_grp1ns_en = 1'b1, ctl_ds = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [4:0]  wr_id = '0;
    logic [7:0]  wr_data = '0;
    logic        eval = 1'b0;
    logic [9:0]  in_id = NONE_ID;
    logic [7:0]  in_prio = 8'hFF;
    logic [1:0]  in_grp = '0;
    logic [9:0]  best_id;
    logic [7:0]  best_prio;
    logic [1:0]  best_grp;
    logic        rescan_req, irq_pend, sgi_pin_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirq_tracker u_pirq_tracker (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int id, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 3'(kind); wr_id = 5'(id); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup_id(input int id, input int prio, input int grp1);
        wr(3, id, grp1);
        wr(6, id, prio);
        wr(0, id, 1);
    endtask

    task automatic run_eval(input int id, input int prio, input int grp);
        @(negedge clk);
        eval = 1'b1; in_id = 10'(id); in_prio = 8'(prio); in_grp = 2'(grp);
        @(negedge clk);
        eval = 1'b0;
    endtask

    task automatic expect_best(input string req, input int id, input int prio, input int grp);
        chk({req, " id"}, best_id, id);
        chk({req, " prio"}, best_prio, prio);
        chk({req, " grp"}, best_grp, grp);
        chk({req, " irq_pend R10"}, irq_pend, prio != 8'hFF);
    endtask

    task automatic t_reset;
        chk("R1 id", best_id, NONE_ID);
        chk("R1 prio", best_prio, 8'hFF);
        chk("R1 grp", best_grp, 0);
        chk("R1 rescan", rescan_req, 0);
        chk("R1 irq", irq_pend, 0);
        chk("R1 err", sgi_pin_err, 0);
    endtask

    task automatic t_basic;
        wr(3, 20, 1); wr(6, 20, 8'h40); wr(1, 20, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R2 disabled", NONE_ID, 8'hFF, 0);
        wr(0, 20, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R2 R5 enabled", 20, 8'h40, 2);
    endtask

    task automatic t_active_rescan;
        wr(2, 20, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R2 active", NONE_ID, 8'hFF, 0);
        chk("R6 no rescan idle", rescan_req, 0);
        run_eval(20, 8'h40, 2);
        expect_best("R6 keep", 20, 8'h40, 2);
        chk("R6 rescan set", rescan_req, 1);
        @(negedge clk);
        chk("R6 rescan pulse", rescan_req, 0);
        run_eval(100, 8'h40, 1);
        expect_best("R6 shared keep", 100, 8'h40, 1);
        chk("R6 shared no rescan", rescan_req, 0);
        wr(2, 20, 0);
    endtask

    task automatic t_order;
        setup_id(25, 8'h40, 1); wr(1, 25, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R4 tie low id", 20, 8'h40, 2);
        wr(6, 25, 8'h30);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R4 lower prio", 25, 8'h30, 2);
        run_eval(24, 8'h30, 0);
        expect_best("R4 equal prio higher id loses", 24, 8'h30, 0);
        chk("R6 rescan on loss", rescan_req, 1);
        run_eval(25, 8'h30, 0);
        expect_best("R4 equal id wins", 25, 8'h30, 2);
        chk("R6 no rescan on win", rescan_req, 0);
        run_eval(40, 8'h20, 1);
        expect_best("R4 shared better", 40, 8'h20, 1);
        wr(0, 25, 0);
    endtask

    task automatic t_groups;
        wr(3, 20, 0); wr(4, 20, 1);
        @(negedge clk);
        ctl_grp0_en = 1'b0; ctl_grp1s_en = 1'b0; ctl_grp1ns_en = 1'b1;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R3 g1s off", NONE_ID, 8'hFF, 0);
        ctl_grp1s_en = 1'b1;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R3 R5 g1s on", 20, 8'h40, 1);
        ctl_ds = 1'b1; ctl_grp1ns_en = 1'b0;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R3 ds forces g0", NONE_ID, 8'hFF, 0);
        ctl_grp0_en = 1'b1;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R3 R5 ds g0 on", 20, 8'h40, 0);
        ctl_ds = 1'b0; ctl_grp1ns_en = 1'b1;
    endtask

    task automatic t_edge;
        setup_id(27, 8'h10, 1); wr(5, 27, 1);
        @(negedge clk); pin_in[27] = 1'b1;
        @(negedge clk); pin_in[27] = 1'b0;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R7 edge latched", 27, 8'h10, 2);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R7 latch holds", 27, 8'h10, 2);
        wr(1, 27, 0);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R7 cleared", 20, 8'h40, 1);
    endtask

    task automatic t_level;
        setup_id(28, 8'h08, 1);
        @(negedge clk); pin_in[28] = 1'b1;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R8 level high", 28, 8'h08, 2);
        @(negedge clk); pin_in[28] = 1'b0;
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R8 level low", 20, 8'h40, 1);
    endtask

    task automatic t_sgi_pin;
        setup_id(3, 8'h00, 1);
        @(negedge clk); pin_in[3] = 1'b1;
        @(negedge clk);
        chk("R9 err flag", sgi_pin_err, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R9 pin ignored", 20, 8'h40, 1);
        pin_in[3] = 1'b0;
        @(negedge clk);
        chk("R9 err clears", sgi_pin_err, 0);
    endtask

    task automatic t_hold;
        wr(6, 20, 8'h05);
        wr(2, 20, 1);
        repeat (3) @(negedge clk);
        expect_best("R11 hold", 20, 8'h40, 1);
        run_eval(NONE_ID, 8'hFF, 0);
        expect_best("R11 after eval", NONE_ID, 8'hFF, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_active_rescan();
        t_order();
        t_groups();
        t_edge();
        t_level();
        t_sgi_pin();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule